// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a cycle-accurate, synthesizable model of a synchronous SRAM that can change between reads and writes on every clock edge without idle cycles. Each command is sampled on a rising edge. The two-cycle data slot that belongs to a command works the same way for reads and writes. For a read, the output register loads the word one edge after the command, and the host samples it on the second edge. For a write, the host drives the data during that same cycle, and the storage takes it in on the second edge. A write address therefore passes through two pipeline stages before its data arrives.

A read that targets a word still waiting for its write data returns the bytes of that pending write together with the stored bytes of the lanes it does not select. A two-bit burst counter serves runs of up to four words from one loaded address. It counts in linear or interleaved order. A global clock enable freezes the whole pipeline. Three chip enables qualify each new command. A synchronous drive flag, gated by an external output-enable input, tells the pad logic when the block owns the data bus.

Top module: `zt_burst_sram`

## Requirements
- R1: A read command sampled at edge k loads `rdata` at edge k+1, with `rdata_oe` high during the cycle between edge k+1 and edge k+2. The write data for a write command sampled at edge k is taken from `wdata` at edge k+2.
- R2: While `clk_en` is low, no register changes on a clock edge. This covers the pipeline, the burst state, `rdata`, the drive flag and the storage. The enabled cycle is stretched.
- R3: Any mix of read, write and deselect commands may be issued on consecutive enabled edges, and every command is served in its own slot.
- R4: The word has four 9-bit lanes. Lane i is `wdata[9i+8:9i]` and is written only when `byte_sel[i]` is 1. Unselected lanes keep their stored value.
- R5: A load cycle (`burst_adv`=0) starts a command only when all three bits of `chip_en` are 1. Otherwise the cycle is a deselect: nothing is written, nothing is driven, and any running burst ends.
- R6: `rdata_oe` is low in the data slot of every write and of every deselect.
- R7: A continue cycle (`burst_adv`=1) during an active burst issues another command of the type that was loaded. `wr_en` and `chip_en` are ignored on that cycle. Outside a burst it is a deselect. `byte_sel` is sampled on every cycle.
- R8: With `order_ilv`=0 captured at load, the n-th continue cycle uses offset (start+n) mod 4 in address bits [1:0]. The upper address bits stay fixed.
- R9: With `order_ilv`=1 captured at load, the n-th continue cycle uses offset start XOR (n mod 4).
- R10: A read whose output loads on the same edge as a pending write's data capture, at the same address, returns the `wdata` lanes selected by that write and the stored value in the other lanes.
- R11: After reset, `rdata` is zero, `rdata_oe` is low, no burst is active, and the first continue cycle is a deselect.
- R12: `rdata_oe` equals the internal drive flag ANDed with `oe_ext`, without a clock. `oe_ext` has no effect on the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | High: edge is active; low: all state holds |
| burst_adv | input | 1 | 0 = load new command, 1 = continue burst |
| wr_en | input | 1 | On load: 1 = write, 0 = read |
| byte_sel | input | 4 | Per-lane write select |
| chip_en | input | 3 | All ones needed to accept a load |
| order_ilv | input | 1 | Burst order captured at load: 0 linear, 1 interleaved |
| addr | input | AW | Word address (AW = log2 of DEPTH) |
| wdata | input | 36 | Write data, taken two edges after its command |
| oe_ext | input | 1 | Asynchronous output-enable gate |
| rdata | output | 36 | Registered read data |
| rdata_oe | output | 1 | Drive enable for the data bus |

## Verification
The assertions assume that `rst_n` is released away from a clock edge and that control inputs are never X on an enabled edge. They also assume the host drives the write data in the cycle right before its capture edge. The stimulus changes every input only at falling edges and drives `wdata` with fresh random values in every cycle, so a capture from the wrong slot shows up as a data mismatch. Addresses in the mixed phases are kept to a handful of words so that read-after-write hits and partial-lane merges occur often.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
    localparam int LANES   = 4;
    localparam int LANE_W  = 9;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/zt_burst_gen.sv
module zt_burst_gen
    import zt_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          load,
    input  logic          sel_ok,
    input  logic          wr_req,
    input  logic          ilv_req,
    input  logic [AW-1:0] addr_in,
    output op_e           op,
    output logic [AW-1:0] addr_out
);
    typedef struct packed {
        logic               act;
        logic               wr;
        logic               ilv;
        logic [AW-1:0]      base;
        logic [BURST_W-1:0] cnt;
    } bst_t;

    bst_t               st_q, st_d;
    logic [BURST_W-1:0] step_n;
    logic [BURST_W-1:0] off;

    always_comb begin
        st_d     = st_q;
        op       = OP_NONE;
        addr_out = addr_in;
        step_n   = st_q.cnt + 1'b1;
        off      = st_q.ilv ? (st_q.base[BURST_W-1:0] ^ step_n)
                            : (st_q.base[BURST_W-1:0] + step_n);
        if (load) begin
            if (sel_ok) begin
                st_d.act  = 1'b1;
                st_d.wr   = wr_req;
                st_d.ilv  = ilv_req;
                st_d.base = addr_in;
                st_d.cnt  = '0;
                op        = wr_req ? OP_WRITE : OP_READ;
            end else begin
                st_d.act  = 1'b0;
            end
        end else if (st_q.act) begin
            st_d.cnt = step_n;
            op       = st_q.wr ? OP_WRITE : OP_READ;
            addr_out = {st_q.base[AW-1:BURST_W], off};
        end
        if (!clk_en) begin
            st_d = st_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: a continue cycle inside a burst advances the count and keeps the type
    a_r7_cont_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !load && st_q.act) |=>
            (st_q.cnt == $past(st_q.cnt) + 2'd1) && (st_q.wr == $past(st_q.wr)));

    // R5: a refused load ends any burst
    a_r5_deselect_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && load && !sel_ok) |=> !st_q.act);
endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array
    import zt_sram_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              clk_en,
    input  logic              wr_go,
    input  logic [AW-1:0]     wr_addr,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    logic addr_hit;

    assign addr_hit = wr_go && (wr_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic              lane_fwd;

        assign lane_fwd = addr_hit && wr_lanes[g];

        always_ff @(posedge clk) begin
            if (clk_en && wr_go && wr_lanes[g]) begin
                bank[wr_addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] =
            lane_fwd ? wdata[g*LANE_W +: LANE_W] : bank[rd_addr];
    end
endmodule

// File: rtl/zt_burst_sram.sv
module zt_burst_sram
    import zt_sram_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              burst_adv,
    input  logic              wr_en,
    input  logic [LANES-1:0]  byte_sel,
    input  logic [2:0]        chip_en,
    input  logic              order_ilv,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              oe_ext,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_oe
);
    typedef struct packed {
        logic             vld;
        logic             wr;
        logic [AW-1:0]    addr;
        logic [LANES-1:0] lanes;
    } slot_t;

    typedef struct packed {
        slot_t             s1;
        slot_t             s2;
        logic              drive;
        logic [WORD_W-1:0] rd;
    } core_t;

    core_t             core_q, core_d;
    op_e               gen_op;
    logic [AW-1:0]     gen_addr;
    logic              wr_go;
    logic [WORD_W-1:0] arr_word;

    zt_burst_gen #(.AW(AW)) i_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .load     (!burst_adv),
        .sel_ok   (&chip_en),
        .wr_req   (wr_en),
        .ilv_req  (order_ilv),
        .addr_in  (addr),
        .op       (gen_op),
        .addr_out (gen_addr)
    );

    assign wr_go = core_q.s2.vld && core_q.s2.wr;

    zt_sram_array #(.DEPTH(DEPTH), .AW(AW)) i_arr (
        .clk      (clk),
        .clk_en   (clk_en),
        .wr_go    (wr_go),
        .wr_addr  (core_q.s2.addr),
        .wr_lanes (core_q.s2.lanes),
        .wdata    (wdata),
        .rd_addr  (core_q.s1.addr),
        .rd_word  (arr_word)
    );

    always_comb begin
        core_d = core_q;
        if (clk_en) begin
            core_d.s1.vld   = (gen_op != OP_NONE);
            core_d.s1.wr    = (gen_op == OP_WRITE);
            core_d.s1.addr  = gen_addr;
            core_d.s1.lanes = byte_sel;
            core_d.s2       = core_q.s1;
            core_d.drive    = core_q.s1.vld && !core_q.s1.wr;
            if (core_q.s1.vld && !core_q.s1.wr) begin
                core_d.rd = arr_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign rdata    = core_q.rd;
    assign rdata_oe = core_q.drive && oe_ext;

    // R2: a disabled edge changes nothing visible or pending
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(rdata) && $stable(core_q.drive) && $stable(core_q.s1)
                     && $stable(core_q.s2)));

    // R6: never drive while a write's data occupies the bus
    a_r6_quiet_write: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.s2.vld && core_q.s2.wr) |-> !rdata_oe);

    // R5: a load without all chip enables is not accepted
    a_r5_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !burst_adv && !(&chip_en)) |=> !core_q.s1.vld);

    // R1: an accepted read leads to the drive slot on the next enabled edge
    a_r1_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && core_q.s1.vld && !core_q.s1.wr) |=> core_q.drive);
endmodule

// File: tb/test_zt_burst_sram.sv
module test_zt_burst_sram;
    localparam int DEPTH = 256;
    localparam int AW    = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clk_en;
    logic        burst_adv;
    logic        wr_en;
    logic [3:0]  byte_sel;
    logic [2:0]  chip_en;
    logic        order_ilv;
    logic [AW-1:0] addr;
    logic [35:0] wdata;
    logic        oe_ext;
    logic [35:0] rdata;
    logic        rdata_oe;

    always #10 clk = ~clk;

    zt_burst_sram #(.DEPTH(DEPTH), .AW(AW)) i_zt_burst_sram (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .burst_adv(burst_adv),
        .wr_en(wr_en), .byte_sel(byte_sel), .chip_en(chip_en),
        .order_ilv(order_ilv), .addr(addr), .wdata(wdata), .oe_ext(oe_ext),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    typedef struct packed {
        logic          v;
        logic          w;
        logic [AW-1:0] a;
        logic [3:0]    bs;
    } rec_t;

    int          total = 0;
    int          bad   = 0;
    logic [35:0] mem_m [DEPTH];
    rec_t        hist[$];
    bit          b_act, b_wr, b_ilv;
    int          b_base, b_n;
    bit          exp_drive;
    logic [35:0] exp_rdata;

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        rec_t cur;
        int   off;
        cur = '0;
        if (!burst_adv) begin
            if (chip_en == 3'b111) begin
                b_act = 1; b_wr = wr_en; b_ilv = order_ilv; b_base = int'(addr); b_n = 0;
                cur.v = 1; cur.w = wr_en; cur.a = addr; cur.bs = byte_sel;
            end else begin
                b_act = 0;
            end
        end else if (b_act) begin
            b_n = (b_n + 1) % 4;
            off = b_ilv ? ((b_base % 4) ^ b_n) : (((b_base % 4) + b_n) % 4);
            cur.v = 1; cur.w = b_wr; cur.a = AW'((b_base / 4) * 4 + off); cur.bs = byte_sel;
        end
        if (hist.size() >= 2 && hist[1].v && hist[1].w) begin
            for (int l = 0; l < 4; l++) begin
                if (hist[1].bs[l]) mem_m[hist[1].a][9*l +: 9] = wdata[9*l +: 9];
            end
        end
        exp_drive = (hist.size() >= 1) && hist[0].v && !hist[0].w;
        if (exp_drive) exp_rdata = mem_m[hist[0].a];
        hist.push_front(cur);
        if (hist.size() > 2) void'(hist.pop_back());
    endtask

    task automatic step(input bit en, input bit adv, input bit wr, input int a,
                        input bit [3:0] bs, input bit [2:0] cs, input bit ilv,
                        input bit oe, input string tag);
        @(negedge clk);
        chk({tag, " oe"}, {35'd0, rdata_oe}, {35'd0, exp_drive & oe_ext});
        if (exp_drive) chk({tag, " data"}, rdata, exp_rdata);
        clk_en = en; burst_adv = adv; wr_en = wr; addr = AW'(a); byte_sel = bs;
        chip_en = cs; order_ilv = ilv; oe_ext = oe;
        wdata = 36'({$urandom(), $urandom()});
        @(posedge clk);
        if (en) model_edge();
    endtask

    task automatic idle(input string tag);
        step(1, 0, 0, 0, 4'h0, 3'b000, 0, 1, tag);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst_n = 0; clk_en = 1; burst_adv = 0; wr_en = 0; addr = '0; byte_sel = '0;
        chip_en = '0; order_ilv = 0; oe_ext = 1; wdata = '0;
        exp_drive = 0; exp_rdata = '0; b_act = 0; b_wr = 0; b_ilv = 0; b_base = 0; b_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R11: reset state at the ports
        chk("R11 reset rdata", rdata, 36'd0);
        chk("R11 reset oe", {35'd0, rdata_oe}, 36'd0);
        // R11: continue right after reset is a deselect
        step(1, 1, 0, 3, 4'hf, 3'b111, 0, 1, "R11");
        step(1, 1, 0, 3, 4'hf, 3'b111, 0, 1, "R11");
        idle("R11"); idle("R11");

        // R1: fill every word, then read back with gaps
        for (int i = 0; i < DEPTH; i++) step(1, 0, 1, i, 4'hf, 3'b111, 0, 1, "R1");
        idle("R1"); idle("R1");
        for (int i = 0; i < 8; i++) begin
            step(1, 0, 0, i * 7, 4'h0, 3'b111, 0, 1, "R1");
            idle("R1");
        end
        idle("R1"); idle("R1");

        // R4: partial lane writes
        step(1, 0, 1, 5, 4'b0101, 3'b111, 0, 1, "R4");
        idle("R4"); idle("R4");
        step(1, 0, 0, 5, 4'h0, 3'b111, 0, 1, "R4");
        step(1, 0, 1, 5, 4'b1010, 3'b111, 0, 1, "R4");
        step(1, 0, 1, 5, 4'b0000, 3'b111, 0, 1, "R4");
        idle("R4"); idle("R4");
        step(1, 0, 0, 5, 4'h0, 3'b111, 0, 1, "R4");
        idle("R4"); idle("R4");

        // R5: deselected writes and reads
        step(1, 0, 1, 6, 4'hf, 3'b110, 0, 1, "R5");
        step(1, 0, 1, 6, 4'hf, 3'b101, 0, 1, "R5");
        step(1, 0, 0, 6, 4'h0, 3'b011, 0, 1, "R5");
        step(1, 1, 0, 6, 4'h0, 3'b111, 0, 1, "R5");
        step(1, 0, 0, 6, 4'h0, 3'b111, 0, 1, "R5");
        idle("R5"); idle("R5");

        // R7: continues inherit type and ignore wr_en and chip_en
        step(1, 0, 0, 16, 4'h0, 3'b111, 0, 1, "R7");
        for (int i = 0; i < 3; i++) step(1, 1, 1, 99, 4'hf, 3'b000, 1, 1, "R7");
        step(1, 0, 1, 20, 4'hf, 3'b111, 0, 1, "R7");
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 4'b0011, 3'b000, 1, 1, "R7");
        step(1, 0, 0, 20, 4'h0, 3'b111, 0, 1, "R7");
        for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 4'h0, 3'b000, 0, 1, "R7");
        idle("R7"); idle("R7");

        // R8: linear order from offset 2 with wrap
        step(1, 0, 1, 34, 4'hf, 3'b111, 0, 1, "R8");
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 4'hf, 3'b111, 0, 1, "R8");
        step(1, 0, 0, 33, 4'h0, 3'b111, 0, 1, "R8");
        for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 4'h0, 3'b111, 0, 1, "R8");
        idle("R8"); idle("R8");

        // R9: interleaved order from offset 3
        step(1, 0, 1, 43, 4'hf, 3'b111, 1, 1, "R9");
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 4'hf, 3'b111, 0, 1, "R9");
        step(1, 0, 0, 41, 4'h0, 3'b111, 1, 1, "R9");
        for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 4'h0, 3'b111, 0, 1, "R9");
        idle("R9"); idle("R9");

        // R10: read right behind a write to the same word
        step(1, 0, 1, 50, 4'hf, 3'b111, 0, 1, "R10");
        step(1, 0, 0, 50, 4'h0, 3'b111, 0, 1, "R10");
        step(1, 0, 1, 51, 4'b0011, 3'b111, 0, 1, "R10");
        step(1, 0, 0, 51, 4'h0, 3'b111, 0, 1, "R10");
        step(1, 0, 1, 51, 4'b1000, 3'b111, 0, 1, "R10");
        idle("R10");
        step(1, 0, 0, 51, 4'h0, 3'b111, 0, 1, "R10");
        idle("R10"); idle("R10");

        // R6: strict alternation on one word
        for (int i = 0; i < 12; i++)
            step(1, 0, i % 2 == 1, 60, 4'hf, 3'b111, 0, 1, "R6");
        idle("R6"); idle("R6");

        // R3: random back-to-back mix on a few words
        for (int i = 0; i < 500; i++)
            step(1, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 7), 4'($urandom_range(0, 15)),
                 ($urandom_range(0, 7) == 0) ? 3'b101 : 3'b111,
                 $urandom_range(0, 1) == 1, 1, "R3");

        // R2: random with clock enable dropping
        for (int i = 0; i < 500; i++)
            step($urandom_range(0, 9) > 2, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 1) == 1, $urandom_range(0, 7),
                 4'($urandom_range(0, 15)), 3'b111,
                 $urandom_range(0, 1) == 1, 1, "R2");

        // R12: random with the external output enable toggling
        for (int i = 0; i < 300; i++)
            step(1, $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0,
                 $urandom_range(0, 7), 4'($urandom_range(0, 15)), 3'b111, 0,
                 $urandom_range(0, 1) == 1, "R12");

        idle("R12"); idle("R12"); idle("R12");
        summary();
        $finish;
    end
endmodule